// File: doc/BRIEF.md
# Slot-Table Egress Transmit Scheduler

This block hands a single shared egress interface to one virtual link (VL) at a time. It follows a time-triggered plan. A prescaler cuts time into fixed slots, and 32 slots make one line of 1 ms. At the nominal clock, a slot lasts 31.25 µs. A table held in the block names the owner VL of each slot, or marks the slot idle. Software fills the table through a write port.

Consecutive slots with the same owner form a run. A run is sized offline so that it covers the worst-case on-chip transfer time plus the frame's wire time, rounded up to whole slots. For example, 51 µs plus 120 µs gives 6 slots. In the first slot of a run, if the owner reports a pending frame, the block pushes one DMA transfer command toward the command FIFO in front of the egress interface. The interface is therefore never handed a second transfer while one is still in flight.

The table repeats every 2^L lines, where L is a configuration value of 0 to 7. A VL with a longer gap between frames is then offered a run at least once per period. A VL may own several runs within one period, which shortens its worst-case wait.

Top module: `slot_tx_sched`

## Requirements
- R1: After reset, `cmd_valid`, `busy` and `overflow` are low, and the repeat length is one line.
- R2: Slot s starts CLKS_PER_SLOT×s clocks after the first clock edge at which `enable` is sampled high. A command belonging to a slot appears on `cmd_valid` one clock after that slot starts and lasts one clock.
- R3: A table entry is written as {`tbl_valid`, `tbl_vl`}, with the valid flag at bit 4 and the VL id in bits 3:0. When a run starts and `vl_ready[id]` is high, one command is issued and `cmd_vl` carries that id.
- R4: A slot starts a run when it is valid and either the previous slot was idle or the previous slot had a different id. No command is ever issued in a later slot of a run, even if the owner becomes ready partway through it.
- R5: If the owner is not ready when its run starts, no command is issued and `busy` stays low for that whole run.
- R6: `busy` rises together with an issued command. It remains high for the rest of that run and falls one clock after the first slot that does not continue the run.
- R7: The slot index wraps after 32×2^L slots, so the table repeats with that period. Entries beyond the period are never used. A run that spans the wrap point continues across it and is not started again.
- R8: `cfg_lines_log2` is taken into the block only while `enable` is low. A write made while the scheduler runs has no effect on the period.
- R9: If `fifo_full` is high when a command is due, that command is dropped and `overflow` is set. `overflow` stays set until reset.
- R10: While `enable` is low, no command is issued and `busy` is low. Each time the scheduler is re-enabled it restarts at slot 0, with no previous slot in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the timebase and the scheduler |
| cfg_we | input | 1 | Write strobe for the repeat length |
| cfg_lines_log2 | input | 3 | Repeat length L; the period is 2^L lines |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 12 | Slot index to write |
| tbl_valid | input | 1 | Slot is owned; when low, the slot is idle |
| tbl_vl | input | 4 | Owner VL id |
| vl_ready | input | 16 | Per-VL flag: a frame is pending |
| fifo_full | input | 1 | The command FIFO cannot accept a command |
| cmd_valid | output | 1 | One-clock push of a transfer command |
| cmd_vl | output | 4 | VL id of the pushed command |
| busy | output | 1 | An issued run is in progress |
| overflow | output | 1 | Sticky flag: a command was dropped |

## Verification
A corrupted slot counter or a wrong prescaler shows up as a command at the wrong clock offset. Because every command falls at a fixed offset of 2 + CLKS_PER_SLOT×s clocks from enable, the bench catches this on the first issued run. A stale copy of the previous-slot entry produces either an extra command inside a run or a missing command at a run boundary. This becomes visible at the first run that is adjacent to another run or that spans the table wrap. A wrong period length moves the second occurrence of a run by a whole period, so it appears no later than two periods into a run.

// File: rtl/slot_tx_sched.sv
module slot_tx_sched #(
  parameter int CLKS_PER_SLOT  = 1563,
  parameter int SLOTS_PER_LINE = 32,
  parameter int MAX_LINES      = 128,
  parameter int NUM_VL         = 16
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        enable,
  input  logic                                        cfg_we,
  input  logic [$clog2($clog2(MAX_LINES)+1)-1:0]      cfg_lines_log2,
  input  logic                                        tbl_we,
  input  logic [$clog2(MAX_LINES*SLOTS_PER_LINE)-1:0] tbl_addr,
  input  logic                                        tbl_valid,
  input  logic [$clog2(NUM_VL)-1:0]                   tbl_vl,
  input  logic [NUM_VL-1:0]                           vl_ready,
  input  logic                                        fifo_full,
  output logic                                        cmd_valid,
  output logic [$clog2(NUM_VL)-1:0]                   cmd_vl,
  output logic                                        busy,
  output logic                                        overflow
);
  localparam int VLW   = $clog2(NUM_VL);
  localparam int DEPTH = MAX_LINES * SLOTS_PER_LINE;
  localparam int IDXW  = $clog2(DEPTH);
  localparam int LLW   = $clog2($clog2(MAX_LINES) + 1);
  localparam int CNTW  = $clog2(CLKS_PER_SLOT);

  logic [VLW:0] tbl [DEPTH];

  always_ff @(posedge clk)
    if (tbl_we) tbl[tbl_addr] <= {tbl_valid, tbl_vl};

  logic [LLW-1:0]  lines_q;
  logic            running, start_p, prev_v;
  logic [VLW-1:0]  prev_vl;
  logic [CNTW-1:0] cnt;
  logic [IDXW-1:0] sidx;

  logic [VLW:0]  entry;
  logic [IDXW:0] period;
  logic          ent_v, run_start, want, tick, wrap;
  logic [VLW-1:0] ent_vl;

  assign entry     = tbl[sidx];
  assign ent_v     = entry[VLW];
  assign ent_vl    = entry[VLW-1:0];
  assign period    = (IDXW+1)'(SLOTS_PER_LINE) << lines_q;
  assign wrap      = ({1'b0, sidx} == period - 1'b1);
  assign tick      = running && (cnt == CNTW'(CLKS_PER_SLOT - 1));
  assign run_start = ent_v && (!prev_v || prev_vl != ent_vl);
  assign want      = start_p && run_start && vl_ready[ent_vl];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q   <= '0;
      running   <= 1'b0;
      start_p   <= 1'b0;
      prev_v    <= 1'b0;
      prev_vl   <= '0;
      cnt       <= '0;
      sidx      <= '0;
      cmd_valid <= 1'b0;
      cmd_vl    <= '0;
      busy      <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (cfg_we && !enable) lines_q <= cfg_lines_log2;
      running   <= enable;
      cmd_valid <= 1'b0;
      if (!enable) begin
        cnt     <= '0;
        sidx    <= '0;
        start_p <= 1'b0;
        prev_v  <= 1'b0;
        busy    <= 1'b0;
      end else begin
        start_p <= !running || tick;
        if (tick) begin
          cnt  <= '0;
          sidx <= wrap ? '0 : sidx + 1'b1;
        end else if (running) begin
          cnt <= cnt + 1'b1;
        end
        if (start_p) begin
          prev_v  <= ent_v;
          prev_vl <= ent_vl;
          if (run_start)  busy <= want && !fifo_full;
          else if (!ent_v) busy <= 1'b0;
          if (want) begin
            if (fifo_full) overflow <= 1'b1;
            else begin
              cmd_valid <= 1'b1;
              cmd_vl    <= ent_vl;
            end
          end
        end
      end
    end
  end

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r2_cmd_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  a_r2_cmd_at_slot_offset: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cnt == CNTW'(1));
  a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(fifo_full));
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!cmd_valid && !busy));
  a_r6_busy_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);
endmodule

// File: tb/slot_tx_sched_test.sv
module slot_tx_sched_test;
  localparam int CPS = 4;
  logic clk = 0, rst_n = 0, enable = 0, cfg_we = 0, tbl_we = 0, tbl_valid = 0, fifo_full = 0;
  logic [2:0] cfg_lines_log2 = 0;
  logic [11:0] tbl_addr = 0;
  logic [3:0] tbl_vl = 0;
  logic [15:0] vl_ready = 0;
  logic cmd_valid, busy, overflow;
  logic [3:0] cmd_vl;

  int checks = 0, failures = 0, cyc = 0;
  int ev_n [16];
  int ev_v [16];
  int ev_cnt;
  bit busyh [600];

  slot_tx_sched #(.CLKS_PER_SLOT(CPS)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_lines_log2(cfg_lines_log2), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_valid(tbl_valid), .tbl_vl(tbl_vl), .vl_ready(vl_ready),
    .fifo_full(fifo_full), .cmd_valid(cmd_valid), .cmd_vl(cmd_vl),
    .busy(busy), .overflow(overflow));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, bit v, int id);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 12'(addr); tbl_valid = v; tbl_vl = 4'(id);
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic clear_table();
    @(negedge clk);
    tbl_we = 1; tbl_valid = 0; tbl_vl = 0;
    for (int a = 0; a < 4096; a++) begin
      tbl_addr = 12'(a);
      @(negedge clk);
    end
    tbl_we = 0;
  endtask

  task automatic set_lines(int l);
    @(negedge clk);
    cfg_we = 1; cfg_lines_log2 = 3'(l);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(int ncyc, int raise_n, logic [15:0] raise_mask, int poke_n);
    ev_cnt = 0;
    @(negedge clk);
    enable = 1;
    for (int n = 1; n <= ncyc; n++) begin
      if (n == poke_n) begin cfg_we = 1; cfg_lines_log2 = 0; end
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0;
      if (n == raise_n) vl_ready = vl_ready | raise_mask;
      if (n < 600) busyh[n] = busy;
      if (cmd_valid && ev_cnt < 16) begin
        ev_n[ev_cnt] = n; ev_v[ev_cnt] = cmd_vl; ev_cnt++;
      end
    end
    enable = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic expect_evs(string req, int cnt, int en [16], int evv [16]);
    chk(ev_cnt == cnt, req, ev_cnt, cnt);
    for (int i = 0; i < cnt && i < ev_cnt; i++) begin
      chk(ev_n[i] == en[i], req, ev_n[i], en[i]);
      chk(ev_v[i] == evv[i], req, ev_v[i], evv[i]);
    end
  endtask

  task automatic t_reset();
    chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
  endtask

  task automatic t_basic();
    int en [16]; int evv [16];
    clear_table(); vl_ready = 0;
    for (int s = 3; s <= 5; s++) wr(s, 1, 2);
    vl_ready[2] = 1;
    run(40, 0, 0, 0);
    en[0] = 2 + 3*CPS; evv[0] = 2;
    expect_evs("R2 R3 basic run", 1, en, evv);
    chk(busyh[14] == 1, "R6 busy at issue", busyh[14], 1);
    chk(busyh[25] == 1, "R6 busy end of run", busyh[25], 1);
    chk(busyh[26] == 0, "R6 busy after run", busyh[26], 0);
  endtask

  task automatic t_adjacent();
    int en [16]; int evv [16];
    clear_table(); vl_ready = 0;
    wr(3, 1, 2); wr(4, 1, 2); wr(5, 1, 5); wr(6, 1, 5); wr(8, 1, 5);
    vl_ready[2] = 1; vl_ready[5] = 1;
    run(50, 0, 0, 0);
    en[0] = 2 + 3*CPS; evv[0] = 2;
    en[1] = 2 + 5*CPS; evv[1] = 5;
    en[2] = 2 + 8*CPS; evv[2] = 5;
    expect_evs("R4 adjacent runs", 3, en, evv);
  endtask

  task automatic t_notready();
    int en [16]; int evv [16];
    clear_table(); vl_ready = 0;
    for (int s = 2; s <= 4; s++) wr(s, 1, 7);
    run(40, 12, 16'h0080, 0);
    expect_evs("R4 R5 ready mid-run", 0, en, evv);
    chk(busyh[14] == 0, "R5 busy low", busyh[14], 0);
    chk(busyh[20] == 0, "R5 busy low late", busyh[20], 0);
  endtask

  task automatic t_wrap();
    int en [16]; int evv [16];
    clear_table(); vl_ready = 0;
    wr(31, 1, 1); wr(0, 1, 1); wr(10, 1, 3);
    vl_ready[1] = 1; vl_ready[3] = 1;
    run(280, 0, 0, 0);
    en[0] = 2;            evv[0] = 1;
    en[1] = 2 + 10*CPS;   evv[1] = 3;
    en[2] = 2 + 31*CPS;   evv[2] = 1;
    en[3] = 2 + 42*CPS;   evv[3] = 3;
    en[4] = 2 + 63*CPS;   evv[4] = 1;
    expect_evs("R7 wrap one line", 5, en, evv);
    chk(busyh[130] == 1, "R7 run continues over wrap", busyh[130], 1);
  endtask

  task automatic t_lines();
    int en [16]; int evv [16];
    clear_table(); vl_ready = 0;
    wr(40, 1, 4); wr(70, 1, 4);
    vl_ready[4] = 1;
    set_lines(1);
    run(440, 0, 0, 50);
    en[0] = 2 + 40*CPS;   evv[0] = 4;
    en[1] = 2 + 104*CPS;  evv[1] = 4;
    expect_evs("R7 R8 two-line period, write while running ignored", 2, en, evv);
    set_lines(0);
  endtask

  task automatic t_full();
    int en [16]; int evv [16];
    clear_table(); vl_ready = 0;
    wr(3, 1, 2); vl_ready[2] = 1;
    fifo_full = 1;
    run(30, 0, 0, 0);
    expect_evs("R9 dropped when full", 0, en, evv);
    chk(overflow == 1, "R9 overflow set", overflow, 1);
    fifo_full = 0;
    run(30, 0, 0, 0);
    en[0] = 2 + 3*CPS; evv[0] = 2;
    expect_evs("R9 issue after full clears", 1, en, evv);
    chk(overflow == 1, "R9 overflow sticky", overflow, 1);
  endtask

  task automatic t_disabled();
    int seen;
    clear_table(); vl_ready = 16'hFFFF;
    wr(0, 1, 6); wr(1, 1, 6);
    seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (cmd_valid || busy) seen++;
    end
    chk(seen == 0, "R10 quiet while disabled", seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic();
    t_adjacent();
    t_notready();
    t_wrap();
    t_lines();
    t_full();
    t_disabled();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule